// File: doc/BRIEF.md
# Tag Frame Encoder with Manchester and Glitch Modulation

This block turns one 64-bit identification code into a modulation waveform for a passive transponder's load switch. On an accepted start request it sends a complete frame: eight encoded zero bits, a synchronisation mark made of two bit periods held low followed by an encoded one, and then the 64 code bits, least significant bit first. The frame is 75 bit periods long. Each bit period is split into four equal quarters, and the level in each quarter depends on the selected modulation.

Two modulations are available. In the half-bit format, a bit drives its own value in the first half of the period and the inverse in the second half. In the glitch format, the output is high for a single quarter only: the first quarter for a one and the third quarter for a zero. This keeps the longest loaded interval to a quarter bit. A 3-bit rate code picks the quarter length. The quarter length is the base divider multiplied by two raised to the rate code, so each step halves the bit rate.

The sequencer runs through five named states. IDLE goes to PREAMBLE on an accepted start. PREAMBLE goes to SYNC_LOW after its eighth bit. SYNC_LOW goes to SYNC_ONE after its second bit. SYNC_ONE goes to CODE after one bit. CODE returns to IDLE after its 64th bit, and the done pulse is raised on that return.

Top module: `tfe_frame_encoder`

## Requirements
- R1: A frame is 75 bit periods long. It starts with 8 bits encoded as zero. Bits 8 and 9 hold the output low for their full periods. Bit 10 is encoded as one. Bits 11 to 74 carry code_i[0] to code_i[63] in that order.
- R2: With glitch_mode_i = 0, a data bit of value v drives v in quarters 0 and 1 and the inverse of v in quarters 2 and 3.
- R3: With glitch_mode_i = 1, a one is high in quarter 0 only, and a zero is high in quarter 2 only.
- R4: Each quarter lasts BASE_DIV × 2^rate_sel_i clock cycles, and a bit period lasts four quarters. Rate codes 0 to 7 therefore halve the bit rate at each step.
- R5: code_i, glitch_mode_i and rate_sel_i are captured when a start is accepted. Changes to them during a frame do not alter that frame.
- R6: A start_i pulse that arrives while busy_o is high is ignored. The running frame continues unchanged.
- R7: busy_o is high from the cycle after an accepted start until the last quarter of bit 74 ends. In the following cycle, done_o is high for exactly one cycle and busy_o is low.
- R8: After reset and whenever idle, mod_o, busy_o and done_o are low. Reset asserted during a frame aborts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 64 | Identification code; bit 0 is sent first |
| start_i | input | 1 | Frame start request, taken only when idle |
| glitch_mode_i | input | 1 | 0 = half-bit format, 1 = quarter-bit glitch format |
| rate_sel_i | input | 3 | Rate code, 0 = fastest, 7 = slowest |
| mod_o | output | 1 | Modulation level |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the last code bit |

## Verification
The bench works through the following corner cases:

- **Synchronisation bits.** A design that encoded these as ordinary zeros would show a high second half or a high third quarter where the line must stay low.
- **Bit order.** Codes with distinct low and high halves are used, so a reversed order would place code_i[63] first.
- **Slowest rate.** A divider that is too narrow would wrap at rate code 7 and shorten every quarter.
- **Mid-frame changes.** In one frame the bench changes the code, the mode and the rate, and pulses start_i. A design that re-sampled these inputs or restarted on the pulse would break the expected sequence.
- **Done timing.** Checking done_o in the cycle after the last bit catches a pulse that arrives one cycle early or late.
- **Mid-frame reset.** A reset during a frame must return every output to low.

// File: rtl/tfe_pkg.sv
package tfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SYNC_LOW,
        ST_SYNC_ONE,
        ST_CODE
    } frame_state_e;

    // Symbol presented to the level shaper for the current bit period
    typedef struct packed {
        logic active;    // a frame is running
        logic hold_low;  // force low for the whole bit period
        logic value;     // encoded bit value
    } symbol_t;

endpackage

// File: rtl/tfe_quarter_tick.sv
module tfe_quarter_tick #(
    parameter int BASE_DIV = 2,
    parameter int RATE_W   = 3,
    localparam int CW      = $clog2(BASE_DIV) + (1 << RATE_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Quarter length doubles with each rate step
    assign limit  = CW'(BASE_DIV) << rate_i;
    assign tick_o = run_i && (cnt == limit - CW'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt <= '0;
        end else if (!run_i || tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/tfe_frame_seq.sv
module tfe_frame_seq
    import tfe_pkg::*;
#(
    parameter int CODE_BITS = 64,
    parameter int PRE_BITS  = 8,
    parameter int SYNC_BITS = 2,
    localparam int MAXB     = (CODE_BITS > PRE_BITS) ? CODE_BITS : PRE_BITS,
    localparam int CNTW     = $clog2(MAXB)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [CODE_BITS-1:0] code_i,
    input  logic                 qtick_i,
    output frame_state_e         state_o,
    output logic [1:0]           quarter_o,
    output symbol_t              sym_o,
    output logic                 done_o
);

    frame_state_e         state, state_n;
    logic [CNTW-1:0]      bit_cnt;
    logic [1:0]           quarter;
    logic [CODE_BITS-1:0] shreg;
    logic                 done_q;
    logic                 bit_end;

    assign bit_end = qtick_i && (quarter == 2'd3);

    // Next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (start_i) state_n = ST_PREAMBLE;
            ST_PREAMBLE: if (bit_end && bit_cnt == CNTW'(PRE_BITS - 1)) state_n = ST_SYNC_LOW;
            ST_SYNC_LOW: if (bit_end && bit_cnt == CNTW'(SYNC_BITS - 1)) state_n = ST_SYNC_ONE;
            ST_SYNC_ONE: if (bit_end) state_n = ST_CODE;
            ST_CODE:     if (bit_end && bit_cnt == CNTW'(CODE_BITS - 1)) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // State register and bit/quarter counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            quarter <= '0;
            shreg   <= '0;
            done_q  <= 1'b0;
        end else begin
            state  <= state_n;
            done_q <= (state == ST_CODE) && (state_n == ST_IDLE);
            if (state != state_n) begin
                bit_cnt <= '0;
            end else if (bit_end) begin
                bit_cnt <= bit_cnt + CNTW'(1);
            end
            if (state == ST_IDLE) begin
                quarter <= '0;
            end else if (qtick_i) begin
                quarter <= quarter + 2'd1;
            end
            if (state == ST_IDLE && start_i) begin
                shreg <= code_i;
            end else if (state == ST_CODE && bit_end) begin
                shreg <= shreg >> 1;
            end
        end
    end

    // Outputs per state
    always_comb begin
        sym_o = '0;
        unique case (state)
            ST_IDLE:     sym_o = '0;
            ST_PREAMBLE: sym_o = '{active: 1'b1, hold_low: 1'b0, value: 1'b0};
            ST_SYNC_LOW: sym_o = '{active: 1'b1, hold_low: 1'b1, value: 1'b0};
            ST_SYNC_ONE: sym_o = '{active: 1'b1, hold_low: 1'b0, value: 1'b1};
            ST_CODE:     sym_o = '{active: 1'b1, hold_low: 1'b0, value: shreg[0]};
            default:     sym_o = '0;
        endcase
    end

    assign state_o   = state;
    assign quarter_o = quarter;
    assign done_o    = done_q;

endmodule

// File: rtl/tfe_bit_shaper.sv
module tfe_bit_shaper
    import tfe_pkg::*;
(
    input  symbol_t    sym_i,
    input  logic [1:0] quarter_i,
    input  logic       glitch_i,
    output logic       level_o
);

    always_comb begin
        if (!sym_i.active || sym_i.hold_low) begin
            level_o = 1'b0;
        end else if (glitch_i) begin
            level_o = sym_i.value ? (quarter_i == 2'd0) : (quarter_i == 2'd2);
        end else begin
            level_o = quarter_i[1] ? ~sym_i.value : sym_i.value;
        end
    end

endmodule

// File: rtl/tfe_frame_encoder.sv
module tfe_frame_encoder
    import tfe_pkg::*;
#(
    parameter int BASE_DIV  = 2,
    parameter int CODE_BITS = 64,
    parameter int RATE_W    = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [CODE_BITS-1:0] code_i,
    input  logic                 start_i,
    input  logic                 glitch_mode_i,
    input  logic [RATE_W-1:0]    rate_sel_i,
    output logic                 mod_o,
    output logic                 busy_o,
    output logic                 done_o
);

    frame_state_e      state;
    logic [1:0]        quarter;
    symbol_t           sym;
    logic              qtick;
    logic              accept;
    logic [RATE_W-1:0] rate_q;
    logic              glitch_q;

    assign busy_o = (state != ST_IDLE);
    assign accept = start_i && !busy_o;

    // Frame settings are frozen at the accepted start
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rate_q   <= '0;
            glitch_q <= 1'b0;
        end else if (accept) begin
            rate_q   <= rate_sel_i;
            glitch_q <= glitch_mode_i;
        end
    end

    tfe_quarter_tick #(
        .BASE_DIV (BASE_DIV),
        .RATE_W   (RATE_W)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (busy_o),
        .rate_i (rate_q),
        .tick_o (qtick)
    );

    tfe_frame_seq #(
        .CODE_BITS (CODE_BITS),
        .PRE_BITS  (8),
        .SYNC_BITS (2)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .code_i    (code_i),
        .qtick_i   (qtick),
        .state_o   (state),
        .quarter_o (quarter),
        .sym_o     (sym),
        .done_o    (done_o)
    );

    tfe_bit_shaper u_shape (
        .sym_i     (sym),
        .quarter_i (quarter),
        .glitch_i  (glitch_q),
        .level_o   (mod_o)
    );

endmodule

// File: rtl/tfe_frame_encoder_chk.sv
module tfe_frame_encoder_chk
    import tfe_pkg::*;
#(
    parameter int RATE_W = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              mod_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [RATE_W-1:0] rate_q,
    input logic              glitch_q,
    input frame_state_e      state
);

    p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !mod_o);

    p_sync_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_SYNC_LOW) |-> !mod_o);

    p_start_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));

    p_settings_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> ($stable(rate_q) && $stable(glitch_q)));

    p_busy_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && state == ST_PREAMBLE) |=> (state != ST_IDLE));

endmodule

bind tfe_frame_encoder tfe_frame_encoder_chk #(.RATE_W(RATE_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mod_o    (mod_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rate_q   (rate_q),
    .glitch_q (glitch_q),
    .state    (state)
);

// File: tb/tfe_frame_encoder_bench.sv
`timescale 1ns/1ps
module tfe_frame_encoder_bench;

    localparam int BASE_DIV = 2;
    localparam int WATCHDOG = 190000;

    typedef struct {
        logic m;
        logic b;
        logic d;
        int   req;
    } item_t;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] code_i = '0;
    logic        start_i = 1'b0;
    logic        glitch_mode_i = 1'b0;
    logic [2:0]  rate_sel_i = '0;
    logic        mod_o, busy_o, done_o;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    finished = 0;

    always #5 clk_i = ~clk_i;

    tfe_frame_encoder #(.BASE_DIV(BASE_DIV)) u_tfe_frame_encoder (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .code_i        (code_i),
        .start_i       (start_i),
        .glitch_mode_i (glitch_mode_i),
        .rate_sel_i    (rate_sel_i),
        .mod_o         (mod_o),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    task automatic check_bit(input logic act, input logic exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle; idle cycles must be quiet (R8)
    always @(negedge clk_i) begin
        if (rst_ni) begin
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check_bit(mod_o, it.m, it.req, "mod_o");
                check_bit(busy_o, it.b, 7, "busy_o");
                check_bit(done_o, it.d, 7, "done_o");
            end else begin
                check_bit(mod_o, 1'b0, 8, "idle mod_o");
                check_bit(busy_o, 1'b0, 8, "idle busy_o");
                check_bit(done_o, 1'b0, 8, "idle done_o");
            end
        end
    end

    function automatic logic level_of(input logic [63:0] code, input logic glitch, input int k, input int qu);
        logic v;
        if (k == 8 || k == 9) return 1'b0;      // R1 synch low
        if (k < 8) v = 1'b0;
        else if (k == 10) v = 1'b1;
        else v = code[k-11];                     // R1 bit 0 first
        if (glitch) return v ? (qu == 0) : (qu == 2);   // R3
        return (qu >= 2) ? ~v : v;                      // R2
    endfunction

    // Driver: starts a frame and pushes the expected per-cycle items (R4 timing)
    task automatic send_frame(input logic [63:0] code, input logic glitch, input logic [2:0] rate);
        int q;
        q = BASE_DIV << rate;
        @(negedge clk_i);
        code_i = code; glitch_mode_i = glitch; rate_sel_i = rate; start_i = 1'b1;
        @(posedge clk_i);
        #1 start_i = 1'b0;
        for (int t = 0; t < 300 * q; t++) begin
            item_t it;
            int k, qu;
            k = t / (4 * q);
            qu = (t / q) % 4;
            it.m = level_of(code, glitch, k, qu);
            it.b = 1'b1;
            it.d = 1'b0;
            it.req = (k == 8 || k == 9) ? 1 : (rate != 0 ? 4 : (glitch ? 3 : 2));
            exp_q.push_back(it);
        end
        begin
            item_t fin;
            fin.m = 1'b0; fin.b = 1'b0; fin.d = 1'b1; fin.req = 7;
            exp_q.push_back(fin);
        end
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk_i);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R8: outputs during reset
        check_bit(mod_o, 1'b0, 8, "reset mod_o");
        check_bit(busy_o, 1'b0, 8, "reset busy_o");
        check_bit(done_o, 1'b0, 8, "reset done_o");
        rst_ni = 1'b1;
        repeat (4) @(negedge clk_i);

        // R1 R2: half-bit format, fastest rate
        send_frame(64'h8000_0000_0000_00F1, 1'b0, 3'd0);
        drain();
        // R3: glitch format, rate 1 (R4)
        send_frame(64'hA5C3_0F96_1234_5678, 1'b1, 3'd1);
        drain();
        // R5 R6: mid-frame start pulse and input changes are ignored
        send_frame(64'h0123_4567_89AB_CDEF, 1'b0, 3'd3);
        repeat (500) @(negedge clk_i);
        code_i = ~code_i; glitch_mode_i = 1'b1; rate_sel_i = 3'd0; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        repeat (3000) @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        drain();
        // R4: slowest rate, glitch
        send_frame(64'hFFFF_0000_DEAD_BEEF, 1'b1, 3'd7);
        drain();
        // R8: reset during a frame
        send_frame(64'h5555_AAAA_3333_CCCC, 1'b0, 3'd2);
        repeat (200) @(negedge clk_i);
        @(posedge clk_i);
        #2 rst_ni = 1'b0;
        exp_q.delete();
        @(negedge clk_i);
        check_bit(mod_o, 1'b0, 8, "abort mod_o");
        check_bit(busy_o, 1'b0, 8, "abort busy_o");
        check_bit(done_o, 1'b0, 8, "abort done_o");
        @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (20) @(negedge clk_i);
        // R1 R2 after recovery
        send_frame(64'h0000_0000_0000_0001, 1'b0, 3'd0);
        drain();

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    always @(posedge clk_i) begin
        cycles++;
        if (cycles >= WATCHDOG && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule